// File: doc/BRIEF.md
# Multi-Stage Conversion Sequence Scheduler

This block paces a sensing front end through one conversion sequence made of a programmable number of measurement stages. Each stage lasts for a fixed number of clock cycles. That number grows with the selected decimation ratio. At the first cycle of every stage the block raises a start strobe and shows the stage index. It pulses a done flag when the last stage has finished.

There are two operating modes. In full-power mode, sequences follow one another with no idle time. In low-power mode, the block finishes a sequence and then drops its awake flag. It sleeps for one of four programmable intervals, then wakes by itself and runs the next sequence. The stage count, decimation, mode and sleep code are captured only when a sequence begins. Changes made in the middle of a sequence therefore wait for the next one.

The timing is set by two parameters: the number of clocks per decimation count, and the number of clocks per sleep step. In silicon, these would be worth 12 µs and 200 ms of real time. In simulation, they can be scaled down.

Top module: `conv_seq_sched`

## Requirements
- R1: While reset is high, and in the cycle after any clock edge with reset high, stageIdx is 0 and stageStart, seqDone and awake are all 0.
- R2: A stage-count value N gives N+1 stages per sequence, indexed 0..N. Any value above 11 is treated as 11, so a sequence has at most 12 stages.
- R3: The decimation select gives stage lengths in clocks of 64, 128 or 256 times CYC_PER_UNIT for codes 00, 01 and 10. Code 11 behaves like 10. For example, N=5 with code 01 ends the sequence after 768·CYC_PER_UNIT cycles.
- R4: stageStart is high for exactly the first cycle of each stage. In that cycle stageIdx shows the stage number, starting at 0 and rising by one per stage.
- R5: seqDone is a one-cycle pulse in the cycle right after the last stage's final cycle. stageIdx goes back to 0 when the next sequence begins.
- R6: In full-power mode (lowPower=0), the next sequence's stage 0 starts in the same cycle as seqDone, with no gap.
- R7: In low-power mode, after seqDone the block sleeps for (code+1)·SLEEP_STEP_CYC cycles, where code is the 2-bit sleep code. During the sleep awake is 0 and no stage starts. The next stage 0 then starts on its own.
- R8: The stage count, decimation, mode and sleep code are sampled only in the cycle a sequence begins. Mid-sequence changes apply from the next sequence.
- R9: The first sequence starts at the first clock edge after reset is released. From then on, awake is 1 throughout every sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stageNum | input | 4 | Stage count minus one (values above 11 are clamped) |
| decSel | input | 2 | Decimation select: 00=64, 01=128, 10/11=256 |
| lowPower | input | 1 | 1 selects low-power wake-up mode |
| sleepCode | input | 2 | Sleep interval code, (code+1) sleep steps |
| stageIdx | output | 4 | Index of the current stage |
| stageStart | output | 1 | One-cycle strobe at the start of each stage |
| seqDone | output | 1 | One-cycle pulse after the last stage ends |
| awake | output | 1 | High while a sequence is running |

## Verification
A wrong cycle counter or a wrongly latched length shows up at the first stage boundary. A start strobe then arrives early or late by a whole number of cycles, at most 256·CYC_PER_UNIT cycles after the sequence begins. A wrong stage limit or mode register is only seen when the sequence ends, through a missing or misplaced done pulse or a missing or extra sleep gap. To catch these, every strobe is compared against the cycle at which it is expected. The scenarios cover mode changes made mid-sequence and a reset applied in the middle of a run.

// File: rtl/seqsched_pkg.sv
package seqsched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SLEEP = 2'd2
  } schedState_t;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic loadSeq;    // capture configuration, begin stage 0
    logic nextStage;  // advance to the following stage
    logic loadSleep;  // load the sleep interval
    logic countDown;  // decrement the shared cycle counter
    logic seqEnd;     // last stage has just finished
  } ctlStrb_t;

endpackage

// File: rtl/seqsched_ctrl.sv
module seqsched_ctrl
  import seqsched_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cntZero,
  input  logic     lastStage,
  input  logic     lpMode,
  output ctlStrb_t ctl,
  output logic     awake
);

  schedState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        ctl.loadSeq = 1'b1;
        stateNxt    = ST_RUN;
      end
      ST_RUN: begin
        if (!cntZero) begin
          ctl.countDown = 1'b1;
        end else if (lastStage) begin
          ctl.seqEnd = 1'b1;
          if (lpMode) begin
            ctl.loadSleep = 1'b1;
            stateNxt      = ST_SLEEP;
          end else begin
            ctl.loadSeq = 1'b1;
          end
        end else begin
          ctl.nextStage = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (!cntZero) begin
          ctl.countDown = 1'b1;
        end else begin
          ctl.loadSeq = 1'b1;
          stateNxt    = ST_RUN;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign awake = (state == ST_RUN);

  // R7
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && !cntZero) |=> (state == ST_SLEEP));

endmodule

// File: rtl/seqsched_dp.sv
module seqsched_dp
  import seqsched_pkg::*;
#(
  parameter int CYC_PER_UNIT   = 1,
  parameter int SLEEP_STEP_CYC = 500,
  parameter int MAX_STAGES     = 12,
  localparam int IW            = $clog2(MAX_STAGES)
)(
  input  logic          clk,
  input  logic          rst,
  input  ctlStrb_t      ctl,
  input  logic [IW-1:0] stageNum,
  input  logic [1:0]    decSel,
  input  logic          lowPower,
  input  logic [1:0]    sleepCode,
  output logic          cntZero,
  output logic          lastStage,
  output logic          lpMode,
  output logic [IW-1:0] stageIdx,
  output logic          stageStart,
  output logic          seqDone
);

  localparam int LAST_MAX  = MAX_STAGES - 1;
  localparam int MAX_STAGE = 256 * CYC_PER_UNIT;
  localparam int MAX_SLEEP = 4 * SLEEP_STEP_CYC;
  localparam int MAX_CNT   = (MAX_STAGE > MAX_SLEEP) ? MAX_STAGE : MAX_SLEEP;
  localparam int CW        = $clog2(MAX_CNT + 1);

  logic [CW-1:0] cnt;
  logic [IW-1:0] lastReg;
  logic [1:0]    decReg, codeReg;
  logic          lpReg;
  logic [IW-1:0] stageClamp;

  function automatic logic [CW-1:0] stageLenM1(input logic [1:0] d);
    int units;
    units = (d == 2'd0) ? 64 : (d == 2'd1) ? 128 : 256;
    return CW'(units * CYC_PER_UNIT - 1);
  endfunction

  function automatic logic [CW-1:0] sleepLenM1(input logic [1:0] c);
    return CW'((int'(c) + 1) * SLEEP_STEP_CYC - 1);
  endfunction

  assign stageClamp = (stageNum > IW'(LAST_MAX)) ? IW'(LAST_MAX) : stageNum;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      stageIdx   <= '0;
      lastReg    <= '0;
      decReg     <= '0;
      codeReg    <= '0;
      lpReg      <= 1'b0;
      stageStart <= 1'b0;
      seqDone    <= 1'b0;
    end else begin
      stageStart <= ctl.loadSeq | ctl.nextStage;
      seqDone    <= ctl.seqEnd;
      if (ctl.loadSeq) begin
        lastReg  <= stageClamp;
        decReg   <= decSel;
        lpReg    <= lowPower;
        codeReg  <= sleepCode;
        stageIdx <= '0;
        cnt      <= stageLenM1(decSel);
      end else if (ctl.nextStage) begin
        stageIdx <= stageIdx + IW'(1);
        cnt      <= stageLenM1(decReg);
      end else if (ctl.loadSleep) begin
        cnt <= sleepLenM1(codeReg);
      end else if (ctl.countDown) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  assign cntZero   = (cnt == '0);
  assign lastStage = (stageIdx == lastReg);
  assign lpMode    = lpReg;

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stageStart |=> !stageStart);

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (stageStart && stageIdx != '0) |-> (stageIdx == $past(stageIdx) + IW'(1)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    seqDone |=> !seqDone);

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    stageIdx <= IW'(LAST_MAX));

  // R6
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (seqDone && !lpReg) |-> (stageStart && stageIdx == '0));

endmodule

// File: rtl/conv_seq_sched.sv
module conv_seq_sched
  import seqsched_pkg::*;
#(
  parameter int CYC_PER_UNIT   = 1,
  parameter int SLEEP_STEP_CYC = 500,
  parameter int MAX_STAGES     = 12,
  localparam int IW            = $clog2(MAX_STAGES)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] stageNum,
  input  logic [1:0]    decSel,
  input  logic          lowPower,
  input  logic [1:0]    sleepCode,
  output logic [IW-1:0] stageIdx,
  output logic          stageStart,
  output logic          seqDone,
  output logic          awake
);

  ctlStrb_t ctl;
  logic     cntZero, lastStage, lpMode;

  seqsched_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cntZero   (cntZero),
    .lastStage (lastStage),
    .lpMode    (lpMode),
    .ctl       (ctl),
    .awake     (awake)
  );

  seqsched_dp #(
    .CYC_PER_UNIT   (CYC_PER_UNIT),
    .SLEEP_STEP_CYC (SLEEP_STEP_CYC),
    .MAX_STAGES     (MAX_STAGES)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .stageNum   (stageNum),
    .decSel     (decSel),
    .lowPower   (lowPower),
    .sleepCode  (sleepCode),
    .cntZero    (cntZero),
    .lastStage  (lastStage),
    .lpMode     (lpMode),
    .stageIdx   (stageIdx),
    .stageStart (stageStart),
    .seqDone    (seqDone)
  );

  // R7
  asleep_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    !awake |-> !stageStart);

endmodule

// File: tb/sim_conv_seq_sched.sv
module sim_conv_seq_sched;

  localparam int BASE = 1;
  localparam int STEP = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] stageNum = '0;
  logic [1:0] decSel = '0;
  logic       lowPower = 1'b0;
  logic [1:0] sleepCode = '0;
  logic [3:0] stageIdx;
  logic       stageStart, seqDone, awake;

  conv_seq_sched #(.CYC_PER_UNIT(BASE), .SLEEP_STEP_CYC(STEP), .MAX_STAGES(12)) u0 (
    .clk(clk), .rst(rst), .stageNum(stageNum), .decSel(decSel),
    .lowPower(lowPower), .sleepCode(sleepCode), .stageIdx(stageIdx),
    .stageStart(stageStart), .seqDone(seqDone), .awake(awake)
  );

  always #5 clk = ~clk;

  typedef struct { int kind; int cyc; int idx; string req; } ev_t;  // kind 0=start, 1=done
  ev_t expQ[$];
  int  nTests = 0, nFail = 0;
  int  edgeCnt = -1;
  bit  monOn = 1'b0;

  always @(posedge clk) begin
    if (rst) edgeCnt <= -1;
    else     edgeCnt <= edgeCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int stageLen(input int dec);
    return ((dec == 0) ? 64 : (dec == 1) ? 128 : 256) * BASE;
  endfunction

  // Driver: push the expected events for one sequence starting at cycle t
  task automatic pushSeq(input int t, input int n, input int dec, input int lp,
                         input int code, input string req, output int tNext);
    int nn = (n > 11) ? 11 : n;
    int len = stageLen(dec);
    for (int k = 0; k <= nn; k++) expQ.push_back('{0, t + k * len, k, req});
    expQ.push_back('{1, t + (nn + 1) * len, 0, req});
    tNext = t + (nn + 1) * len + (lp != 0 ? (code + 1) * STEP : 0);
  endtask

  // Monitor: pop and compare as strobes appear
  task automatic popCheck(input int kind);
    ev_t e;
    if (expQ.size() == 0) begin
      chk(1'b0, "R4", kind == 1 ? "unexpected seqDone at cycle" : "unexpected stageStart at cycle", edgeCnt, -1);
      return;
    end
    e = expQ.pop_front();
    chk(e.kind == kind, e.req, "event kind", kind, e.kind);
    chk(e.cyc == edgeCnt, e.req, kind == 1 ? "seqDone cycle" : "stageStart cycle", edgeCnt, e.cyc);
    if (kind == 0) chk(int'(stageIdx) == e.idx, e.req, "stageIdx at start", stageIdx, e.idx);
  endtask

  always @(negedge clk) begin
    if (monOn && !rst) begin
      if (seqDone)    popCheck(1);
      if (stageStart) popCheck(0);
    end
  end

  task automatic waitUntil(input int c);
    while (edgeCnt < c) @(negedge clk);
  endtask

  task automatic checkResetOutputs(input string what);
    chk(stageIdx == 4'd0, "R1", {what, " stageIdx"}, stageIdx, 0);
    chk(stageStart == 1'b0, "R1", {what, " stageStart"}, stageStart, 0);
    chk(seqDone == 1'b0, "R1", {what, " seqDone"}, seqDone, 0);
    chk(awake == 1'b0, "R1", {what, " awake"}, awake, 0);
  endtask

  task automatic beginRun(input int n, input int dec, input int lp, input int code);
    @(negedge clk);
    monOn = 1'b0;
    rst = 1'b1;
    expQ.delete();
    stageNum = 4'(n); decSel = 2'(dec); lowPower = lp[0]; sleepCode = 2'(code);
    repeat (2) @(negedge clk);
    checkResetOutputs("in reset");
    monOn = 1'b1;
    rst = 1'b0;
  endtask

  task automatic endRun(input int tEnd, input string req);
    waitUntil(tEnd + 1);
    monOn = 1'b0;
    chk(expQ.size() == 0, req, "events left unseen", expQ.size(), 0);
  endtask

  initial begin
    int t1, t2, t3;

    // R3 and R6: N=5, decimation 128, three back-to-back sequences (768 cycles each)
    beginRun(5, 1, 0, 0);
    pushSeq(0, 5, 1, 0, 0, "R3", t1);
    pushSeq(t1, 5, 1, 0, 0, "R6", t2);
    pushSeq(t2, 5, 1, 0, 0, "R6", t3);
    expQ.push_back('{0, t3, 0, "R5"});
    waitUntil(0);
    chk(awake == 1'b1, "R9", "awake at first cycle", awake, 1);
    waitUntil(400);
    chk(awake == 1'b1, "R9", "awake mid sequence", awake, 1);
    endRun(t3, "R6");

    // R2: stage count 15 is clamped to 12 stages
    beginRun(15, 0, 0, 0);
    pushSeq(0, 15, 0, 0, 0, "R2", t1);
    expQ.push_back('{0, t1, 0, "R2"});
    endRun(t1, "R2");

    // R2: single stage, R3: decimation code 10 (256)
    beginRun(0, 2, 0, 0);
    pushSeq(0, 0, 2, 0, 0, "R3", t1);
    pushSeq(t1, 0, 2, 0, 0, "R3", t2);
    expQ.push_back('{0, t2, 0, "R3"});
    endRun(t2, "R3");

    // R3: decimation code 11 behaves like 256
    beginRun(1, 3, 0, 0);
    pushSeq(0, 1, 3, 0, 0, "R3", t1);
    expQ.push_back('{0, t1, 0, "R3"});
    endRun(t1, "R3");

    // R7: low power, sleep code 2 -> 300 cycles asleep
    beginRun(1, 0, 1, 2);
    pushSeq(0, 1, 0, 1, 2, "R7", t1);
    pushSeq(t1, 1, 0, 1, 2, "R7", t2);
    expQ.push_back('{0, t2, 0, "R7"});
    waitUntil(60);
    chk(awake == 1'b1, "R9", "awake during sequence", awake, 1);
    waitUntil(129);
    chk(awake == 1'b0, "R7", "awake after sleep entry", awake, 0);
    waitUntil(t1 - 1);
    chk(awake == 1'b0, "R7", "awake at last sleep cycle", awake, 0);
    waitUntil(t1);
    chk(awake == 1'b1, "R7", "awake after wake-up", awake, 1);
    endRun(t2, "R7");

    // R7: sleep code 0 (100 cycles) and code 3 (400 cycles)
    beginRun(0, 0, 1, 0);
    pushSeq(0, 0, 0, 1, 0, "R7", t1);
    expQ.push_back('{0, t1, 0, "R7"});
    endRun(t1, "R7");
    beginRun(2, 0, 1, 3);
    pushSeq(0, 2, 0, 1, 3, "R7", t1);
    expQ.push_back('{0, t1, 0, "R7"});
    endRun(t1, "R7");

    // R8: configuration changed mid-sequence only applies to the next one
    beginRun(2, 0, 0, 0);
    pushSeq(0, 2, 0, 0, 0, "R8", t1);       // 3 x 64, ends at 192
    pushSeq(t1, 1, 1, 1, 1, "R8", t2);      // then 2 x 128 in low power, sleep 200
    expQ.push_back('{0, t2, 0, "R8"});
    waitUntil(50);
    stageNum = 4'd1; decSel = 2'd1; lowPower = 1'b1; sleepCode = 2'd1;
    waitUntil(t1 + 10);
    stageNum = 4'd7; decSel = 2'd2; lowPower = 1'b0;  // applies after the sleep
    endRun(t2, "R8");

    // R1: reset in the middle of a run
    beginRun(3, 0, 0, 0);
    pushSeq(0, 3, 0, 0, 0, "R1", t1);
    waitUntil(100);
    monOn = 1'b0;
    rst = 1'b1;
    expQ.delete();
    @(negedge clk);
    checkResetOutputs("after mid-run reset");
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule